// File: doc/BRIEF.md
# Shared Memory Bus Takeover Master

This block lets a secondary controller borrow an 8-bit microprocessor memory bus and run byte reads and writes on it. A host issues a command through a valid/ready port. The block then asks for the bus with an active-low request. It waits for the active-low acknowledge, drives a 19-bit address and runs memory cycles. These use active-low memory-request, read and write strobes, and the data direction is switched as each cycle needs. When the work is done, the block hands the bus back in a fixed order and returns to idle.

Four operations are supported. A single read returns one byte on a response strobe. A single write stores one byte. A fill writes the same byte to a run of consecutive addresses. A block write stores a run of bytes that the host supplies one at a time on a pull strobe. Fill and block runs keep memory-request low across the whole run. If the acknowledge does not change within a set number of cycles, the block flags an error, drops its request and goes back to idle.

Address and data drivers are given as separate output-enable signals, so the pads outside the block can float the bus whenever the bus is not owned.

Top module: `extBusMaster`

## Requirements
- R1: After reset the following outputs are all high: memory-request, read strobe, write strobe, bus-request and the interrupt line `nmiN`. Both output enables are low. `cmdReady` is high and `ackTimeout` is low.
- R2: When a command is accepted, the block drives `busReqN` low. `addrOe` rises only after `busAckN` has been seen low, and it is never high while `busAckN` is high.
- R3: The bus is released in three steps, in this order: `dataOe` goes low, then `addrOe` goes low, then `busReqN` goes high. After a normal release, `cmdReady` returns only once `busAckN` reads high again.
- R4: Op code 2'b01 is a single write, and `cmdLen` is ignored for it. Write strobes only happen while memory-request is low and `dataOe` is high. `wrN` stays low for WR_LOW cycles. The target sees `cmdData` at the full 19-bit `cmdAddr`, including address 0 and address 0x7FFFF.
- R5: Op code 2'b00 is a single read, and `cmdLen` is ignored for it. `dataOe` stays low while `rdN` is low, and `rdN` stays low for at least RD_HOLD cycles with memory-request low around it. The byte sampled on `dataIn` is returned on `rspData` during the single cycle that `rspValid` is high.
- R6: Op code 2'b10 is a fill. It writes `cmdData` to `cmdLen`+1 consecutive addresses. The address increments by one per byte and wraps modulo 2^19. There is exactly one write pulse per byte, and memory-request stays low for the whole run.
- R7: Op code 2'b11 is a block write of `cmdLen`+1 bytes. For each byte, `blkPull` is high for one cycle and `blkData` is taken in that same cycle. The bytes land in order at consecutive addresses, all within a single memory-request period.
- R8: `cmdReady` is high only while the block is idle. A command is accepted only on a cycle where both `cmdValid` and `cmdReady` are high.
- R9: If `busAckN` has not answered within ACK_TIMEOUT cycles of a request or release, `ackTimeout` is set. The block then returns to idle with `busReqN` high and no memory cycle run. `ackTimeout` is cleared when the next command is accepted.

Op codes on `cmdOp`: 2'b00 read, 2'b01 write, 2'b10 fill, 2'b11 block write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Host command valid |
| cmdReady | output | 1 | Block idle, command can be taken |
| cmdOp | input | 2 | Operation code |
| cmdAddr | input | 19 | Start address |
| cmdData | input | 8 | Write or fill byte |
| cmdLen | input | 8 | Byte count minus one for fill and block write |
| blkPull | output | 1 | Block write byte is taken this cycle |
| blkData | input | 8 | Block write byte from the host |
| rspValid | output | 1 | Read byte valid |
| rspData | output | 8 | Read byte |
| ackTimeout | output | 1 | Acknowledge wait expired |
| busReqN | output | 1 | Bus request, active low |
| busAckN | input | 1 | Bus acknowledge, active low |
| addrOut | output | 19 | Address bus value |
| addrOe | output | 1 | Address driver enable |
| dataOut | output | 8 | Data bus value when driving |
| dataIn | input | 8 | Data bus value when reading |
| dataOe | output | 1 | Data driver enable |
| mreqN | output | 1 | Memory request, active low |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| nmiN | output | 1 | Non-maskable interrupt line, held inactive high |

## Verification
The test starts with a 256-byte block write of a computed pattern over one full page. Every byte is then read back one at a time, so an address step that skips a byte or a read sampled at the wrong time shows up at a specific byte. Single writes to address 0 and to the all-ones address check that the full address reaches the bus at both ends. A three-byte fill that crosses the top of the address space checks the wrap and the single memory-request period. A run with the acknowledge held inactive checks the timeout path, and the command after it checks that the error flag clears and normal service resumes.

// File: rtl/ebm_pkg.sv
package ebm_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_FILL  = 2'b10,
    OP_BLOCK = 2'b11
  } opE;

  typedef enum logic [3:0] {
    S_IDLE, S_ACQ, S_OWN,
    S_WDATA, S_WLOW, S_WHIGH, S_WEND,
    S_RMREQ, S_RLOW, S_RHIGH, S_REND,
    S_RLSDATA, S_RLSADDR, S_RLSWAIT
  } stateE;

  // strobes from control to datapath, all active high
  typedef struct packed {
    logic busReq;
    logic addrOe;
    logic dataOe;
    logic mreq;
    logic rd;
    logic wr;
    logic loadCmd;
    logic pullBlk;
    logic capture;
    logic nextByte;
  } strobeT;

endpackage

// File: rtl/ebm_ctrl.sv
module ebm_ctrl
  import ebm_pkg::*;
#(
  parameter int ACK_TIMEOUT = 64,
  parameter int RD_HOLD     = 2,
  parameter int WR_LOW      = 1
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   cmdValid,
  input  opE     cmdOp,
  input  logic   busAckN,
  input  logic   lastByte,
  output strobeT strb,
  output logic   cmdReady,
  output logic   rspValid,
  output logic   ackTimeout
);

  localparam int TO_W   = $clog2(ACK_TIMEOUT + 1);
  localparam int PH_MAX = (RD_HOLD > WR_LOW) ? RD_HOLD : WR_LOW;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(ACK_TIMEOUT - 1);
  localparam logic [PH_W-1:0] RD_LAST = PH_W'(RD_HOLD - 1);
  localparam logic [PH_W-1:0] WR_LAST = PH_W'(WR_LOW - 1);

  stateE           state, stateNext;
  opE              opReg;
  logic [TO_W-1:0] toCnt;
  logic [PH_W-1:0] phCnt;
  logic            errReg;
  logic            setErr;

  always_comb begin
    stateNext = state;
    strb      = '0;
    cmdReady  = 1'b0;
    rspValid  = 1'b0;
    setErr    = 1'b0;
    unique case (state)
      S_IDLE: begin
        cmdReady = 1'b1;
        if (cmdValid) begin
          strb.loadCmd = 1'b1;
          stateNext    = S_ACQ;
        end
      end
      S_ACQ: begin
        strb.busReq = 1'b1;
        if (!busAckN) stateNext = S_OWN;
        else if (toCnt == TO_LAST) begin
          setErr    = 1'b1;
          stateNext = S_IDLE;
        end
      end
      S_OWN: begin
        strb.busReq = 1'b1;
        strb.addrOe = 1'b1;
        if (opReg == OP_READ) stateNext = S_RMREQ;
        else begin
          strb.pullBlk = (opReg == OP_BLOCK);
          stateNext    = S_WDATA;
        end
      end
      S_WDATA: begin
        strb.busReq = 1'b1;
        strb.addrOe = 1'b1;
        strb.dataOe = 1'b1;
        strb.mreq   = 1'b1;
        stateNext   = S_WLOW;
      end
      S_WLOW: begin
        strb.busReq = 1'b1;
        strb.addrOe = 1'b1;
        strb.dataOe = 1'b1;
        strb.mreq   = 1'b1;
        strb.wr     = 1'b1;
        if (phCnt == WR_LAST) stateNext = S_WHIGH;
      end
      S_WHIGH: begin
        strb.busReq = 1'b1;
        strb.addrOe = 1'b1;
        strb.dataOe = 1'b1;
        strb.mreq   = 1'b1;
        if (lastByte || opReg == OP_WRITE) stateNext = S_WEND;
        else begin
          strb.nextByte = 1'b1;
          strb.pullBlk  = (opReg == OP_BLOCK);
          stateNext     = S_WDATA;
        end
      end
      S_WEND: begin
        strb.busReq = 1'b1;
        strb.addrOe = 1'b1;
        strb.dataOe = 1'b1;
        stateNext   = S_RLSDATA;
      end
      S_RMREQ: begin
        strb.busReq = 1'b1;
        strb.addrOe = 1'b1;
        strb.mreq   = 1'b1;
        stateNext   = S_RLOW;
      end
      S_RLOW: begin
        strb.busReq = 1'b1;
        strb.addrOe = 1'b1;
        strb.mreq   = 1'b1;
        strb.rd     = 1'b1;
        if (phCnt == RD_LAST) begin
          strb.capture = 1'b1;
          stateNext    = S_RHIGH;
        end
      end
      S_RHIGH: begin
        strb.busReq = 1'b1;
        strb.addrOe = 1'b1;
        strb.mreq   = 1'b1;
        rspValid    = 1'b1;
        stateNext   = S_REND;
      end
      S_REND: begin
        strb.busReq = 1'b1;
        strb.addrOe = 1'b1;
        stateNext   = S_RLSDATA;
      end
      S_RLSDATA: begin
        strb.busReq = 1'b1;
        strb.addrOe = 1'b1;
        stateNext   = S_RLSADDR;
      end
      S_RLSADDR: begin
        strb.busReq = 1'b1;
        stateNext   = S_RLSWAIT;
      end
      S_RLSWAIT: begin
        if (busAckN) stateNext = S_IDLE;
        else if (toCnt == TO_LAST) begin
          setErr    = 1'b1;
          stateNext = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      opReg  <= OP_READ;
      toCnt  <= '0;
      phCnt  <= '0;
      errReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (strb.loadCmd) opReg <= cmdOp;
      toCnt <= (stateNext != state) ? '0 : toCnt + 1'b1;
      phCnt <= (stateNext != state) ? '0 : phCnt + 1'b1;
      if (setErr) errReg <= 1'b1;
      else if (strb.loadCmd) errReg <= 1'b0;
    end
  end

  assign ackTimeout = errReg;

endmodule

// File: rtl/ebm_datapath.sv
module ebm_datapath
  import ebm_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [DATA_W-1:0] blkData,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] rspData,
  output logic              addrOe,
  output logic              dataOe,
  output logic              mreqN,
  output logic              rdN,
  output logic              wrN,
  output logic              busReqN,
  output logic              blkPull,
  output logic              lastByte
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] rdReg;
  logic [LEN_W-1:0]  remReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      rdReg   <= '0;
      remReg  <= '0;
    end else begin
      if (strb.loadCmd) begin
        addrReg <= cmdAddr;
        dataReg <= cmdData;
        remReg  <= cmdLen;
      end
      if (strb.nextByte) begin
        addrReg <= addrReg + 1'b1;
        remReg  <= remReg - 1'b1;
      end
      if (strb.pullBlk) dataReg <= blkData;
      if (strb.capture) rdReg   <= dataIn;
    end
  end

  assign addrOut  = addrReg;
  assign dataOut  = dataReg;
  assign rspData  = rdReg;
  assign lastByte = (remReg == '0);
  assign blkPull  = strb.pullBlk;
  assign addrOe   = strb.addrOe;
  assign dataOe   = strb.dataOe;
  assign mreqN    = ~strb.mreq;
  assign rdN      = ~strb.rd;
  assign wrN      = ~strb.wr;
  assign busReqN  = ~strb.busReq;

endmodule

// File: rtl/extBusMaster.sv
module extBusMaster
  import ebm_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 8,
  parameter int LEN_W       = 8,
  parameter int ACK_TIMEOUT = 64,
  parameter int RD_HOLD     = 2,
  parameter int WR_LOW      = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [LEN_W-1:0]  cmdLen,
  output logic              blkPull,
  input  logic [DATA_W-1:0] blkData,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              ackTimeout,
  output logic              busReqN,
  input  logic              busAckN,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrOe,
  output logic [DATA_W-1:0] dataOut,
  input  logic [DATA_W-1:0] dataIn,
  output logic              dataOe,
  output logic              mreqN,
  output logic              rdN,
  output logic              wrN,
  output logic              nmiN
);

  strobeT strb;
  logic   lastByte;

  ebm_ctrl #(
    .ACK_TIMEOUT(ACK_TIMEOUT),
    .RD_HOLD    (RD_HOLD),
    .WR_LOW     (WR_LOW)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdOp     (opE'(cmdOp)),
    .busAckN   (busAckN),
    .lastByte  (lastByte),
    .strb      (strb),
    .cmdReady  (cmdReady),
    .rspValid  (rspValid),
    .ackTimeout(ackTimeout)
  );

  ebm_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LEN_W (LEN_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cmdAddr (cmdAddr),
    .cmdData (cmdData),
    .cmdLen  (cmdLen),
    .blkData (blkData),
    .dataIn  (dataIn),
    .addrOut (addrOut),
    .dataOut (dataOut),
    .rspData (rspData),
    .addrOe  (addrOe),
    .dataOe  (dataOe),
    .mreqN   (mreqN),
    .rdN     (rdN),
    .wrN     (wrN),
    .busReqN (busReqN),
    .blkPull (blkPull),
    .lastByte(lastByte)
  );

  assign nmiN = 1'b1;

endmodule

// File: rtl/ebm_checker.sv
module ebm_checker #(
  parameter int ACK_TIMEOUT = 64,
  parameter int RD_HOLD     = 2
) (
  input logic clk,
  input logic rstN,
  input logic cmdReady,
  input logic ackTimeout,
  input logic busReqN,
  input logic busAckN,
  input logic addrOe,
  input logic dataOe,
  input logic mreqN,
  input logic rdN,
  input logic wrN
);

  localparam int CW = $clog2(ACK_TIMEOUT + RD_HOLD + 4) + 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] rdLowCnt;
  logic [CW-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdLowCnt <= '0;
      waitCnt  <= '0;
    end else begin
      rdLowCnt <= !rdN ? ((rdLowCnt == CMAX) ? CMAX : rdLowCnt + 1'b1) : '0;
      waitCnt  <= (!busReqN && busAckN) ? ((waitCnt == CMAX) ? CMAX : waitCnt + 1'b1) : '0;
    end
  end

  a_r2_addr_needs_ack: assert property (@(posedge clk) disable iff (!rstN)
    addrOe |-> !busAckN);

  a_r3_data_off_before_addr: assert property (@(posedge clk) disable iff (!rstN)
    $fell(addrOe) |-> !dataOe);

  a_r3_bus_free_on_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReqN) |-> (!addrOe && !dataOe));

  a_r4_write_framed: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> (!mreqN && dataOe && rdN));

  a_r5_read_framed: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> (!mreqN && !dataOe && wrN));

  a_r5_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdN) |-> (rdLowCnt >= CW'(RD_HOLD)));

  a_r8_ready_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (busReqN && !addrOe && mreqN));

  a_r9_wait_bounded: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= CW'(ACK_TIMEOUT));

  a_r9_timeout_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackTimeout) |-> (busReqN && cmdReady));

endmodule

bind extBusMaster ebm_checker #(
  .ACK_TIMEOUT(ACK_TIMEOUT),
  .RD_HOLD    (RD_HOLD)
) u_ebmChecker (
  .clk       (clk),
  .rstN      (rstN),
  .cmdReady  (cmdReady),
  .ackTimeout(ackTimeout),
  .busReqN   (busReqN),
  .busAckN   (busAckN),
  .addrOe    (addrOe),
  .dataOe    (dataOe),
  .mreqN     (mreqN),
  .rdN       (rdN),
  .wrN       (wrN)
);

// File: tb/extBusMaster_bench.sv
`timescale 1ns/1ps
module extBusMaster_bench;

  localparam int RD_HOLD = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [1:0]  cmdOp = 2'b00;
  logic [18:0] cmdAddr = '0;
  logic [7:0]  cmdData = '0;
  logic [7:0]  cmdLen = '0;
  logic        blkPull;
  logic [7:0]  blkData;
  logic        rspValid;
  logic [7:0]  rspData;
  logic        ackTimeout;
  logic        busReqN;
  logic        busAckN;
  logic [18:0] addrOut;
  logic        addrOe;
  logic [7:0]  dataOut;
  logic [7:0]  dataIn;
  logic        dataOe;
  logic        mreqN, rdN, wrN, nmiN;

  always #4 clk = ~clk;

  extBusMaster u_extBusMaster (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdLen(cmdLen),
    .blkPull(blkPull), .blkData(blkData), .rspValid(rspValid), .rspData(rspData),
    .ackTimeout(ackTimeout), .busReqN(busReqN), .busAckN(busAckN),
    .addrOut(addrOut), .addrOe(addrOe), .dataOut(dataOut), .dataIn(dataIn),
    .dataOe(dataOe), .mreqN(mreqN), .rdN(rdN), .wrN(wrN), .nmiN(nmiN)
  );

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  // acknowledge responder: follows the request two cycles later when enabled
  logic       ackEn = 1'b1;
  logic [1:0] ackPipe;
  always_ff @(posedge clk) begin
    if (!rstN) ackPipe <= 2'b11;
    else ackPipe <= {ackPipe[0], busReqN | ~ackEn};
  end
  assign busAckN = ackPipe[1];

  // block data source
  logic blkClr = 1'b0;
  int   blkIdx;
  always_ff @(posedge clk) begin
    if (blkClr) blkIdx <= 0;
    else if (blkPull) blkIdx <= blkIdx + 1;
  end
  assign blkData = pat(blkIdx);

  // memory target and bus monitor
  logic [7:0]  mem [256];
  assign dataIn = (!rdN && !mreqN) ? mem[addrOut[7:0]] : 8'hEE;

  int          wrPulses, mreqPeriods, protoErr, rdShort, rdLen;
  logic [18:0] lastWrAddr;
  logic [7:0]  rspVal;
  logic        gotRsp;
  logic        pWrN, pMreqN, pBusReqN, pRdN;

  always @(negedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      wrPulses = 0; mreqPeriods = 0; protoErr = 0; rdShort = 0; rdLen = 0;
      lastWrAddr = '0; gotRsp = 1'b0; rspVal = '0;
      pWrN = 1'b1; pMreqN = 1'b1; pBusReqN = 1'b1; pRdN = 1'b1;
    end else begin
      if (!pWrN && wrN) begin
        wrPulses++;
        mem[addrOut[7:0]] = dataOut;
        lastWrAddr = addrOut;
      end
      if (pMreqN && !mreqN) mreqPeriods++;
      if (addrOe && busAckN) protoErr++;
      if (pBusReqN == 1'b0 && busReqN && (addrOe || dataOe)) protoErr++;
      if (!wrN && (mreqN || !dataOe)) protoErr++;
      if (!rdN) rdLen++;
      if (!pRdN && rdN) begin
        if (rdLen < RD_HOLD) rdShort++;
        rdLen = 0;
      end
      if (rspValid) begin
        gotRsp = 1'b1;
        rspVal = rspData;
      end
      pWrN = wrN; pMreqN = mreqN; pBusReqN = busReqN; pRdN = rdN;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doCmd(input logic [1:0] op, input logic [18:0] addr,
                       input logic [7:0] data, input logic [7:0] len);
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdOp = op; cmdAddr = addr; cmdData = data; cmdLen = len;
    cmdValid = 1'b1;
    gotRsp = 1'b0;
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R8 ready low after accept", {31'd0, cmdReady}, 32'd0);
    while (!cmdReady) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int w0, m0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 mreqN", {31'd0, mreqN}, 32'd1);
    chk("R1 rdN", {31'd0, rdN}, 32'd1);
    chk("R1 wrN", {31'd0, wrN}, 32'd1);
    chk("R1 busReqN", {31'd0, busReqN}, 32'd1);
    chk("R1 nmiN", {31'd0, nmiN}, 32'd1);
    chk("R1 addrOe", {31'd0, addrOe}, 32'd0);
    chk("R1 dataOe", {31'd0, dataOe}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 cmdReady", {31'd0, cmdReady}, 32'd1);
    chk("R1 ackTimeout", {31'd0, ackTimeout}, 32'd0);

    // R7 block write of a full page
    blkClr = 1'b1;
    @(negedge clk);
    blkClr = 1'b0;
    w0 = wrPulses; m0 = mreqPeriods;
    doCmd(2'b11, 19'h12300, 8'h00, 8'd255);
    chk("R7 write pulses", wrPulses - w0, 256);
    chk("R7 one mreq period", mreqPeriods - m0, 1);
    chk("R7 pulls", blkIdx, 256);
    chk("R7 last address", {13'd0, lastWrAddr}, 32'h123FF);
    for (int i = 0; i < 256; i++) chk("R7 page byte", {24'd0, mem[i]}, {24'd0, pat(i)});
    chk("R3 ack high at idle", {31'd0, busAckN}, 32'd1);

    // R5 read every byte back, length field ignored
    for (int i = 0; i < 256; i++) begin
      doCmd(2'b00, 19'h12300 + 19'(i), 8'h00, 8'h55);
      chk("R5 read response seen", {31'd0, gotRsp}, 32'd1);
      chk("R5 read data", {24'd0, rspVal}, {24'd0, pat(i)});
    end

    // R4 single writes at both address extremes, length ignored
    w0 = wrPulses;
    doCmd(2'b01, 19'h00000, 8'hA5, 8'd9);
    chk("R4 one pulse", wrPulses - w0, 1);
    chk("R4 address zero", {13'd0, lastWrAddr}, 32'h0);
    chk("R4 data zero", {24'd0, mem[8'h00]}, 32'hA5);
    doCmd(2'b01, 19'h7FFFF, 8'h5A, 8'd0);
    chk("R4 address top", {13'd0, lastWrAddr}, 32'h7FFFF);
    chk("R4 data top", {24'd0, mem[8'hFF]}, 32'h5A);
    doCmd(2'b00, 19'h7FFFF, 8'h00, 8'h00);
    chk("R5 read top", {24'd0, rspVal}, 32'h5A);

    // R6 fill across the address wrap
    w0 = wrPulses; m0 = mreqPeriods;
    doCmd(2'b10, 19'h7FFFE, 8'h3C, 8'd2);
    chk("R6 pulses", wrPulses - w0, 3);
    chk("R6 one mreq period", mreqPeriods - m0, 1);
    chk("R6 wrapped address", {13'd0, lastWrAddr}, 32'h0);
    chk("R6 byte FE", {24'd0, mem[8'hFE]}, 32'h3C);
    chk("R6 byte FF", {24'd0, mem[8'hFF]}, 32'h3C);
    chk("R6 byte 00", {24'd0, mem[8'h00]}, 32'h3C);
    chk("R6 neighbour untouched", {24'd0, mem[8'hFD]}, {24'd0, pat(253)});

    // R9 acknowledge never arrives
    ackEn = 1'b0;
    w0 = wrPulses; m0 = mreqPeriods;
    doCmd(2'b01, 19'h00010, 8'h77, 8'd0);
    chk("R9 error flag", {31'd0, ackTimeout}, 32'd1);
    chk("R9 request dropped", {31'd0, busReqN}, 32'd1);
    chk("R9 no write", wrPulses - w0, 0);
    chk("R9 no mreq", mreqPeriods - m0, 0);
    chk("R9 memory kept", {24'd0, mem[8'h10]}, {24'd0, pat(16)});
    ackEn = 1'b1;
    repeat (4) @(negedge clk);
    doCmd(2'b00, 19'h7FFFE, 8'h00, 8'h00);
    chk("R9 flag cleared", {31'd0, ackTimeout}, 32'd0);
    chk("R9 service resumes", {24'd0, rspVal}, 32'h3C);

    chk("R2 R3 R4 bus protocol", protoErr, 0);
    chk("R5 read hold", rdShort, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule